// File: doc/BRIEF.md
# Single-Clock FIFO with Threshold Flags

This block is a first-in first-out buffer clocked by one clock. A producer presents a word with a write strobe. A consumer pulls words with a read strobe and sees each one on the data output one cycle later, together with a valid pulse. Around the storage sits a set of status outputs:

- a full flag and an empty flag;
- a one-slot-left flag and a one-word-left flag;
- an exact occupancy count, which can optionally be narrowed;
- a high-water flag with separate set and clear levels, so it does not chatter when the fill level hovers;
- a low-water flag with a single level;
- three per-cycle report pulses, which say whether the previous cycle's write was taken, whether it was refused, and whether the previous cycle's read was refused.

The reset is synchronous and active low. The three threshold levels are static input ports. The depth must be a power of two. The clear level must be strictly below the set level.

Top module: `sync_fifo_th`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its pointers and registers. After that edge the outputs read as follows: `empty`=1, `full`=0, `occupancy`=0, `dout`=0, and `data_valid`, `wr_ack`, `overflow`, `underflow` and `prog_full` are all 0. `prog_empty`=1.
- R2: Words leave in the order they were accepted. A read accepted at edge k places the oldest stored word on `dout` after edge k.
- R3: A write while full is refused when `rd_en` is low. `overflow` is then 1 for the following cycle, and the stored words and the count do not change.
- R4: A read while empty is refused. `underflow` is then 1 for the following cycle. A write in that same cycle is still accepted.
- R5: A write and a read in the same cycle while full are both accepted. The count stays at DEPTH, and `wr_ack` is 1 in the next cycle.
- R6: `wr_ack` is 1 in exactly the cycle after an accepted write, and 0 otherwise.
- R7: `full` is 1 when the count equals DEPTH, and `empty` is 1 when it equals 0. `almost_full` is 1 when the count equals DEPTH-1, and `almost_empty` is 1 when it equals 1.
- R8: `occupancy` equals the exact number of stored words. When OCC_W is narrower than log2(DEPTH)+1, it carries the upper OCC_W bits of that number.
- R9: `prog_full` becomes 1 when the count is at or above `pf_set_lvl`. It becomes 0 when the count is below `pf_clr_lvl`. At counts between the two levels it keeps its previous value.
- R10: `prog_empty` is 1 exactly when the count is less than or equal to `pe_lvl`.
- R11: `data_valid` is 1 only in the cycle after an accepted read. In any other cycle it is 0 and `dout` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | DATA_W | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| pf_set_lvl | input | log2(DEPTH)+1 | Count at which the high-water flag sets |
| pf_clr_lvl | input | log2(DEPTH)+1 | Count below which the high-water flag clears |
| pe_lvl | input | log2(DEPTH)+1 | Low-water level |
| dout | output | DATA_W | Read data, one cycle after the accepted read |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count equals zero |
| almost_full | output | 1 | Count equals DEPTH-1 |
| almost_empty | output | 1 | Count equals one |
| prog_full | output | 1 | High-water flag with hysteresis |
| prog_empty | output | 1 | Low-water flag |
| wr_ack | output | 1 | Previous write was accepted |
| overflow | output | 1 | Previous write was refused |
| underflow | output | 1 | Previous read was refused |
| data_valid | output | 1 | `dout` holds a freshly read word |
| occupancy | output | OCC_W | Stored word count (upper bits when narrowed) |

## Verification
The assertions take for granted that the clear level is strictly below the set level and that both levels lie within 0..DEPTH. The hysteresis checks depend on this. They also assume the thresholds stay constant while out of reset. The stimulus therefore fixes all three levels at legal constants for the whole run. It varies only the request pattern, in phases that push the buffer to full, drain it to empty and hover around the thresholds.

// File: rtl/sync_fifo_th_pkg.sv
// Package: shared helpers and the per-cycle acceptance record for the FIFO.
// Assumes the depth parameter is a power of two.
package sync_fifo_th_pkg;

    // Width needed to hold counts 0..depth inclusive.
    function automatic int cnt_width(input int depth);
        return $clog2(depth) + 1;
    endfunction

    // Acceptance decision of the current cycle.
    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } fifo_acc_t;

endpackage

// File: rtl/sync_fifo_th_ctrl.sv
// Control: decides which requests are accepted, keeps the pointers and the
// exact word count. Assumes DEPTH is a power of two so pointers wrap freely.
module sync_fifo_th_ctrl
    import sync_fifo_th_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = cnt_width(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    output fifo_acc_t       acc,
    output logic [AW-1:0]   wptr,
    output logic [AW-1:0]   rptr,
    output logic [CW-1:0]   cnt,
    output logic [CW-1:0]   cnt_nxt,
    output logic            full,
    output logic            empty
);

    // Flags derived from the registered count.
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // Acceptance: a read needs data; a write needs room or a read in the same cycle.
    always_comb begin
        acc.rd_ok = rd_en && !empty;
        acc.wr_ok = wr_en && (!full || acc.rd_ok);
    end

    // Next count from the accepted operations.
    assign cnt_nxt = cnt + CW'(acc.wr_ok) - CW'(acc.rd_ok);

    // Pointer and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (acc.wr_ok) wptr <= wptr + 1'b1;
            if (acc.rd_ok) rptr <= rptr + 1'b1;
            cnt <= cnt_nxt;
        end
    end

    // R8: count never exceeds capacity
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R3: refused write while full leaves the count unchanged
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> $stable(cnt));

    // R4: refused read while empty without a write keeps the FIFO empty
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> (cnt == '0));

    // R5: both requests at full keep the count at capacity
    assert_full_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en) |=> (cnt == CW'(DEPTH)));

endmodule

// File: rtl/sync_fifo_th_store.sv
// Storage: word array with a registered read port (one-cycle latency) and the
// matching valid pulse. A read and write to the same slot returns the old word.
module sync_fifo_th_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Array write; no reset on storage.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read data and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
            if (re) rdata <= mem[raddr];
        end
    end

    // R11: data output only moves together with a valid pulse
    assert_dout_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> $stable(rdata));

endmodule

// File: rtl/sync_fifo_th_status.sv
// Status: threshold flags and per-cycle request reports. Assumes the clear
// level sits strictly below the set level and thresholds are static.
module sync_fifo_th_status
    import sync_fifo_th_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = cnt_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  fifo_acc_t     acc,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] pf_set_lvl,
    input  logic [CW-1:0] pf_clr_lvl,
    input  logic [CW-1:0] pe_lvl,
    output logic          almost_full,
    output logic          almost_empty,
    output logic          prog_full,
    output logic          prog_empty,
    output logic          wr_ack,
    output logic          overflow,
    output logic          underflow
);

    // Level flags decoded from the registered count.
    assign almost_full  = (cnt == CW'(DEPTH - 1));
    assign almost_empty = (cnt == CW'(1));
    assign prog_empty   = (cnt <= pe_lvl);

    // High-water flag with hysteresis, updated from the next count.
    always_ff @(posedge clk) begin
        if (!rst_n)                     prog_full <= 1'b0;
        else if (cnt_nxt >= pf_set_lvl) prog_full <= 1'b1;
        else if (cnt_nxt < pf_clr_lvl)  prog_full <= 1'b0;
    end

    // One-cycle-late reports on the requests just seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack    <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            wr_ack    <= acc.wr_ok;
            overflow  <= wr_en && !acc.wr_ok;
            underflow <= rd_en && !acc.rd_ok;
        end
    end

    // R9: flag only rises at or above the set level
    assert_pf_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_full) |-> (cnt >= pf_set_lvl));

    // R9: flag only falls below the clear level
    assert_pf_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_full) |-> (cnt < pf_clr_lvl));

    // R6: acknowledge and refusal of a write are exclusive
    assert_ack_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ack, overflow}));

    // R3: overflow follows a write request
    assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(wr_en));

endmodule

// File: rtl/sync_fifo_th.sv
// Top: single-clock FIFO with threshold flags and request reports.
// Assumes DEPTH is a power of two, OCC_W <= log2(DEPTH)+1, and static
// thresholds with pf_clr_lvl < pf_set_lvl.
module sync_fifo_th
    import sync_fifo_th_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int OCC_W  = $clog2(DEPTH) + 1,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = cnt_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CW-1:0]     pf_set_lvl,
    input  logic [CW-1:0]     pf_clr_lvl,
    input  logic [CW-1:0]     pe_lvl,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              prog_full,
    output logic              prog_empty,
    output logic              wr_ack,
    output logic              overflow,
    output logic              underflow,
    output logic              data_valid,
    output logic [OCC_W-1:0]  occupancy
);

    fifo_acc_t     acc;
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt, cnt_nxt;

    sync_fifo_th_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .acc(acc), .wptr(wptr), .rptr(rptr), .cnt(cnt), .cnt_nxt(cnt_nxt),
        .full(full), .empty(empty)
    );

    sync_fifo_th_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(acc.wr_ok), .waddr(wptr), .wdata(din),
        .re(acc.rd_ok), .raddr(rptr), .rdata(dout), .rvalid(data_valid)
    );

    sync_fifo_th_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .acc(acc),
        .cnt(cnt), .cnt_nxt(cnt_nxt), .pf_set_lvl(pf_set_lvl),
        .pf_clr_lvl(pf_clr_lvl), .pe_lvl(pe_lvl),
        .almost_full(almost_full), .almost_empty(almost_empty),
        .prog_full(prog_full), .prog_empty(prog_empty),
        .wr_ack(wr_ack), .overflow(overflow), .underflow(underflow)
    );

    // Occupancy output: full width, or upper bits when narrowed.
    generate
        if (OCC_W >= CW) begin : g_occ_full
            assign occupancy = OCC_W'(cnt);
        end else begin : g_occ_trunc
            assign occupancy = cnt[CW-1 -: OCC_W];
        end
    endgenerate

    // R11: a valid word follows only a read request that met a non-empty FIFO
    assert_dv_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> ($past(rd_en) && !$past(empty)));

    // R4: underflow follows a read request made while empty
    assert_udf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($past(rd_en) && $past(empty)));

    // R7: full and empty never together
    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: tb/sync_fifo_th_tb.sv
`timescale 1ns/1ps
module sync_fifo_th_tb;

    localparam int DW = 8;
    localparam int DEPTH = 16;
    localparam int CW = 5;       // log2(16)+1
    localparam int NW = 3;       // narrowed count width
    localparam int SET = 12, CLR = 6, PE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] dout, dout_n;
    logic full, empty, afull, aempty, pfull, pempty, ack, ovf, udf, dv;
    logic [CW-1:0] occ;
    logic [NW-1:0] occ_n;
    logic full_n, empty_n, afull_n, aempty_n, pfull_n, pempty_n, ack_n, ovf_n, udf_n, dv_n;

    always #2.5 clk = ~clk;

    sync_fifo_th #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .rd_en(rd_en),
        .pf_set_lvl(CW'(SET)), .pf_clr_lvl(CW'(CLR)), .pe_lvl(CW'(PE)),
        .dout(dout), .full(full), .empty(empty), .almost_full(afull),
        .almost_empty(aempty), .prog_full(pfull), .prog_empty(pempty),
        .wr_ack(ack), .overflow(ovf), .underflow(udf), .data_valid(dv),
        .occupancy(occ)
    );

    sync_fifo_th #(.DATA_W(DW), .DEPTH(DEPTH), .OCC_W(NW)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .rd_en(rd_en),
        .pf_set_lvl(CW'(SET)), .pf_clr_lvl(CW'(CLR)), .pe_lvl(CW'(PE)),
        .dout(dout_n), .full(full_n), .empty(empty_n), .almost_full(afull_n),
        .almost_empty(aempty_n), .prog_full(pfull_n), .prog_empty(pempty_n),
        .wr_ack(ack_n), .overflow(ovf_n), .underflow(udf_n), .data_valid(dv_n),
        .occupancy(occ_n)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // Reference model state
    logic [DW-1:0] q[$];
    logic [DW-1:0] m_dout;
    bit m_dv, m_ack, m_ovf, m_udf, m_pf;

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_pe(input int n); return n <= PE; endfunction
    function automatic int exp_narrow(input int n); return n >> (CW - NW); endfunction

    task automatic check_all();
        int n = q.size();
        chk("R8", "occupancy", int'(occ), n);
        chk("R8", "narrow occupancy", int'(occ_n), exp_narrow(n));
        chk("R7", "full", int'(full), int'(n == DEPTH));
        chk("R7", "empty", int'(empty), int'(n == 0));
        chk("R7", "almost_full", int'(afull), int'(n == DEPTH - 1));
        chk("R7", "almost_empty", int'(aempty), int'(n == 1));
        chk("R9", "prog_full", int'(pfull), int'(m_pf));
        chk("R10", "prog_empty", int'(pempty), int'(exp_pe(n)));
        chk("R6", "wr_ack", int'(ack), int'(m_ack));
        chk("R3", "overflow", int'(ovf), int'(m_ovf));
        chk("R4", "underflow", int'(udf), int'(m_udf));
        chk("R11", "data_valid", int'(dv), int'(m_dv));
        chk("R2", "dout", int'(dout), int'(m_dout));
    endtask

    // One cycle: drive at the falling edge, predict, check after the next falling edge.
    task automatic step(input bit we, input bit re, input logic [DW-1:0] d);
        int n = q.size();
        bit rok = re && (n > 0);
        bit wok = we && ((n < DEPTH) || rok);
        wr_en = we; rd_en = re; din = d;
        if (rok) m_dout = q.pop_front();
        if (wok) q.push_back(d);
        m_dv = rok; m_ack = wok; m_ovf = we && !wok; m_udf = re && !rok;
        if (q.size() >= SET) m_pf = 1;
        else if (q.size() < CLR) m_pf = 0;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; rd_en = 0;
        repeat (4) @(negedge clk);
        q.delete();
        m_dout = '0; m_dv = 0; m_ack = 0; m_ovf = 0; m_udf = 0; m_pf = 0;
        rst_n = 1;
        // R1: values right after reset
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "occupancy", int'(occ), 0);
        chk("R1", "dout", int'(dout), 0);
        chk("R1", "flags", int'({dv, ack, ovf, udf, pfull}), 0);
        chk("R1", "prog_empty", int'(pempty), 1);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unused = $urandom(32'h5EED_1234);
        do_reset();
        // Directed: fill past capacity (R3 overflow, R7 full, R9 rise)
        for (int i = 0; i < DEPTH + 3; i++) step(1, 0, DW'(8'h30 + i));
        // R5: write and read together while full
        step(1, 1, 8'hA5);
        chk("R5", "ack at full", int'(ack), 1);
        chk("R5", "count at full", int'(occ), DEPTH);
        // Drain past empty (R2 order, R4 underflow, R9 fall)
        for (int i = 0; i < DEPTH + 3; i++) step(0, 1, 8'h00);
        // R4: read on empty with a write
        step(1, 1, 8'h77);
        chk("R4", "write taken while empty", int'(occ), 1);
        step(0, 1, 8'h00);
        chk("R2", "word after empty", int'(dout), 8'h77);
        // Random phases with varying bias
        for (int ph = 0; ph < 40; ph++) begin
            int wp = (ph % 4 == 0) ? 85 : (ph % 4 == 1) ? 15 : 50;
            int rp = (ph % 4 == 0) ? 20 : (ph % 4 == 1) ? 80 : 50;
            for (int c = 0; c < 60; c++)
                step(($urandom % 100) < wp, ($urandom % 100) < rp, DW'($urandom));
        end
        // Reset after activity (R1)
        for (int i = 0; i < 5; i++) step(1, 0, DW'(i));
        do_reset();
        step(0, 0, 8'h00);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule